// File: doc/BRIEF.md
# Pipeline Bypass and Load-Use Stall Control

This block sits beside a five-stage in-order integer pipeline and decides, every cycle, where each ALU operand comes from and whether the front of the pipeline must hold. It compares the two source register numbers of the instruction now in execute with the destination registers of the two older instructions still in flight. When one of the older results is newer than what the register file would return, it steers the operand multiplexer to that result instead.

In parallel it checks whether the instruction in execute is a load whose destination is needed by the instruction being decoded. The loaded data cannot reach that consumer in time, so the block inserts one bubble. It does this by clearing the control fields entering the execute-stage pipeline register while holding the program counter and the fetch/decode register. The held instruction is then decoded again on the next cycle, and by then the load result can be bypassed from the writeback side.

The block is purely combinational. Every output follows its inputs in the same cycle, so it fits between the pipeline registers without adding latency.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Each operand select uses the encoding 2'b00 = register file value, 2'b10 = result held after execute (memory-stage result), 2'b01 = result held after memory (writeback-stage result); the value 2'b11 never appears.
- R2: Operand A select is 2'b10 when the memory-stage write flag is set, its destination is non-zero and it equals `ex_rs1`.
- R3: Operand B select is 2'b10 when the memory-stage write flag is set, its destination is non-zero and it equals `ex_rs2`.
- R4: An operand select is 2'b01 when the writeback-stage write flag is set, its destination is non-zero and equals that operand's source, and the memory-stage condition of R2/R3 does not hold for that operand.
- R5: When both the memory stage and the writeback stage match the same source, the memory-stage result (2'b10) is selected.
- R6: A producer whose destination is register 0, or whose write flag is clear, never causes a select other than 2'b00.
- R7: A stall is raised when `ex_is_load` is set, `ex_rd` is non-zero and `ex_rd` equals `id_rs1` or `id_rs2`.
- R8: No stall is raised when `ex_is_load` is clear, when `ex_rd` is zero, or when `ex_rd` matches neither decode source.
- R9: During a stall `idex_bubble` is 1 and both `pc_en` and `ifid_en` are 0. Otherwise `idex_bubble` is 0 and both enables are 1.
- R10: All outputs reflect the inputs of the same cycle, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| mem_rd | input | AW | Destination of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register-write flag of the instruction in the memory stage |
| wb_rd | input | AW | Destination of the instruction in writeback |
| wb_wr_en | input | 1 | Register-write flag of the instruction in writeback |
| ex_rd | input | AW | Destination of the instruction in execute |
| ex_is_load | input | 1 | Memory-read flag of the instruction in execute |
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| alu_a_sel | output | 2 | Operand A multiplexer select |
| alu_b_sel | output | 2 | Operand B multiplexer select |
| idex_bubble | output | 1 | Clears the control fields entering the execute-stage register |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode register update enable |

## Verification
The checks assume the producer flags are meaningful on every cycle: a write flag that is clear really means no result will be written, whatever value the destination field holds. They also assume register numbers only ever lie within the AW-bit range. The stimulus presents one full set of pipeline fields per cycle and changes it only between clock edges. It covers x0 destinations with write flags set, write flags cleared on matching destinations, and loads whose destination is zero, so every case stays within what the pipeline would legally present.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB_RES  = 2'b01,
    SEL_MEM_RES = 2'b10
  } opnd_sel_e;

endpackage

// File: rtl/hzc_src_match.sv
module hzc_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wr,
  output logic          hit
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dst_live;

  // A destination of register 0 never carries a usable result.
  always_comb begin
    dst_live = wr && (dst != ZERO_REG);
    hit      = dst_live && (dst == src);
  end

endmodule

// File: rtl/hzc_bypass_sel.sv
module hzc_bypass_sel
  import hzc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr_en,
  output opnd_sel_e     sel
);

  logic mem_hit;
  logic wb_hit;

  hzc_src_match #(.AW(AW)) u_mem_cmp (
    .src (src),
    .dst (mem_rd),
    .wr  (mem_wr_en),
    .hit (mem_hit)
  );

  hzc_src_match #(.AW(AW)) u_wb_cmp (
    .src (src),
    .dst (wb_rd),
    .wr  (wb_wr_en),
    .hit (wb_hit)
  );

  // The younger producer wins: its value supersedes the older one.
  always_comb begin
    if (mem_hit)     sel = SEL_MEM_RES;
    else if (wb_hit) sel = SEL_WB_RES;
    else             sel = SEL_REGFILE;
  end

endmodule

// File: rtl/hzc_loaduse.sv
module hzc_loaduse #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic               ld_en,
  input  logic [AW-1:0]      ld_rd,
  input  logic [NSRC*AW-1:0] srcs,
  output logic               stall
);

  logic [NSRC-1:0] src_hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzc_src_match #(.AW(AW)) u_cmp (
      .src (srcs[g*AW +: AW]),
      .dst (ld_rd),
      .wr  (ld_en),
      .hit (src_hit[g])
    );
  end

  always_comb stall = |src_hit;

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hzc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr_en,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_load,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  output logic [1:0]    alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic          idex_bubble,
  output logic          pc_en,
  output logic          ifid_en
);

  localparam int NOPS = 2;

  logic [AW-1:0] ex_src [NOPS];
  opnd_sel_e     op_sel [NOPS];
  logic          ld_stall;

  always_comb begin
    ex_src[0] = ex_rs1;
    ex_src[1] = ex_rs2;
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_opnd
    hzc_bypass_sel #(.AW(AW)) u_sel (
      .src       (ex_src[k]),
      .mem_rd    (mem_rd),
      .mem_wr_en (mem_wr_en),
      .wb_rd     (wb_rd),
      .wb_wr_en  (wb_wr_en),
      .sel       (op_sel[k])
    );
  end

  hzc_loaduse #(.AW(AW), .NSRC(NOPS)) u_ldu (
    .ld_en (ex_is_load),
    .ld_rd (ex_rd),
    .srcs  ({id_rs2, id_rs1}),
    .stall (ld_stall)
  );

  always_comb begin
    alu_a_sel   = op_sel[0];
    alu_b_sel   = op_sel[1];
    idex_bubble = ld_stall;
    pc_en       = ~ld_stall;
    ifid_en     = ~ld_stall;
  end

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wr_en,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wr_en,
  input logic [AW-1:0] ex_rd,
  input logic          ex_is_load,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic [1:0]    alu_a_sel,
  input logic [1:0]    alu_b_sel,
  input logic          idex_bubble,
  input logic          pc_en,
  input logic          ifid_en
);

  localparam logic [AW-1:0] Z = '0;

  always_comb begin
    // R1
    sel_legal_chk: assert (alu_a_sel != 2'b11 && alu_b_sel != 2'b11)
      else $error("illegal operand select");
    // R6
    mem_src_live_chk: assert (alu_a_sel != 2'b10 ||
                              (mem_wr_en && mem_rd != Z && mem_rd == ex_rs1))
      else $error("memory-stage bypass without live producer");
    // R6
    wb_src_live_chk: assert (alu_b_sel != 2'b01 ||
                             (wb_wr_en && wb_rd != Z && wb_rd == ex_rs2))
      else $error("writeback bypass without live producer");
    // R5
    young_wins_chk: assert (!(mem_wr_en && mem_rd != Z && mem_rd == ex_rs1) ||
                            alu_a_sel == 2'b10)
      else $error("older result chosen over younger");
    // R9
    freeze_chk: assert (pc_en == ifid_en && idex_bubble == !pc_en)
      else $error("bubble and freeze disagree");
    // R7
    stall_cause_chk: assert (!idex_bubble ||
                             (ex_is_load && ex_rd != Z && (ex_rd == id_rs1 || ex_rd == id_rs2)))
      else $error("stall without load-use dependency");
  end

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.AW(AW)) u_chk (
  .ex_rs1      (ex_rs1),
  .ex_rs2      (ex_rs2),
  .mem_rd      (mem_rd),
  .mem_wr_en   (mem_wr_en),
  .wb_rd       (wb_rd),
  .wb_wr_en    (wb_wr_en),
  .ex_rd       (ex_rd),
  .ex_is_load  (ex_is_load),
  .id_rs1      (id_rs1),
  .id_rs2      (id_rs2),
  .alu_a_sel   (alu_a_sel),
  .alu_b_sel   (alu_b_sel),
  .idex_bubble (idex_bubble),
  .pc_en       (pc_en),
  .ifid_en     (ifid_en)
);

// File: tb/tb_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctl;

  localparam int AW = 5;

  logic clk;
  logic rst_n;
  logic [AW-1:0] ex_rs1, ex_rs2, mem_rd, wb_rd, ex_rd, id_rs1, id_rs2;
  logic mem_wr_en, wb_wr_en, ex_is_load;
  logic [1:0] alu_a_sel, alu_b_sel;
  logic idex_bubble, pc_en, ifid_en;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       stall;
    string      tag;
  } exp_t;

  exp_t sb[$];

  pipe_hazard_ctl #(.AW(AW)) dut (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .wb_rd(wb_rd), .wb_wr_en(wb_wr_en), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .idex_bubble(idex_bubble), .pc_en(pc_en), .ifid_en(ifid_en)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Expected select from R2..R6 with the R1 encoding.
  function automatic logic [1:0] want_sel(input logic [AW-1:0] s,
      input logic [AW-1:0] md, input logic mw, input logic [AW-1:0] wd, input logic ww);
    logic mem_ok, wb_ok;
    mem_ok = mw && (md != 0) && (md == s);
    wb_ok  = ww && (wd != 0) && (wd == s);
    return mem_ok ? 2'b10 : (wb_ok ? 2'b01 : 2'b00);
  endfunction

  // Expected stall from R7/R8.
  function automatic logic want_stall(input logic ld, input logic [AW-1:0] rd,
      input logic [AW-1:0] s1, input logic [AW-1:0] s2);
    return ld && (rd != 0) && (rd == s1 || rd == s2);
  endfunction

  task automatic drive(input logic [AW-1:0] r1, input logic [AW-1:0] r2,
      input logic [AW-1:0] md, input logic mw, input logic [AW-1:0] wd, input logic ww,
      input logic [AW-1:0] erd, input logic ld, input logic [AW-1:0] i1,
      input logic [AW-1:0] i2, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    ex_rs1 = r1; ex_rs2 = r2; mem_rd = md; mem_wr_en = mw; wb_rd = wd; wb_wr_en = ww;
    ex_rd = erd; ex_is_load = ld; id_rs1 = i1; id_rs2 = i2;
    e.a     = want_sel(r1, md, mw, wd, ww);
    e.b     = want_sel(r2, md, mw, wd, ww);
    e.stall = want_stall(ld, erd, i1, i2);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares away from the active edge, same cycle as driven (R10).
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (alu_a_sel !== e.a) begin
        errors++;
        $display("FAIL %s operand A sel: got %b expected %b", e.tag, alu_a_sel, e.a);
      end
      checks++;
      if (alu_b_sel !== e.b) begin
        errors++;
        $display("FAIL %s operand B sel: got %b expected %b", e.tag, alu_b_sel, e.b);
      end
      checks++;
      if (idex_bubble !== e.stall || pc_en !== !e.stall || ifid_en !== !e.stall) begin
        errors++;
        $display("FAIL %s (R9) bubble/pc/ifid: got %b%b%b expected %b%b%b", e.tag,
                 idex_bubble, pc_en, ifid_en, e.stall, !e.stall, !e.stall);
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R10: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_wr_en = 0; wb_rd = 0; wb_wr_en = 0;
    ex_rd = 0; ex_is_load = 0; id_rs1 = 0; id_rs2 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // Idle state after reset: register file, no stall (R1, R9)
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    // R2: operand A from memory stage
    drive(3, 4, 3, 1, 9, 1, 0, 0, 1, 2, "R2");
    // R3: operand B from memory stage
    drive(6, 7, 7, 1, 0, 0, 0, 0, 1, 2, "R3");
    // R4: both operands from writeback
    drive(8, 8, 2, 1, 8, 1, 0, 0, 1, 2, "R4");
    // R4: A from memory stage, B from writeback
    drive(5, 9, 5, 1, 9, 1, 0, 0, 1, 2, "R4 mixed");
    // R5: both stages produce the same register
    drive(11, 11, 11, 1, 11, 1, 0, 0, 1, 2, "R5");
    // R6: x0 destinations with write flags set
    drive(0, 0, 0, 1, 0, 1, 0, 0, 1, 2, "R6 x0");
    // R6: matching destinations with write flags clear
    drive(12, 13, 12, 0, 13, 0, 0, 0, 1, 2, "R6 wr clear");
    // R5/R6: memory-stage flag clear lets writeback through
    drive(14, 14, 14, 0, 14, 1, 0, 0, 1, 2, "R6 fallback");
    // R7: load-use on decode rs1
    drive(1, 2, 0, 0, 0, 0, 17, 1, 17, 3, "R7 rs1");
    // R7: load-use on decode rs2, with bypass active at the same time
    drive(4, 2, 4, 1, 0, 0, 18, 1, 3, 18, "R7 rs2");
    // R8: same register but not a load
    drive(1, 2, 0, 0, 0, 0, 19, 0, 19, 19, "R8 not load");
    // R8: load to x0
    drive(1, 2, 0, 0, 0, 0, 0, 1, 0, 0, "R8 x0");
    // R8: load with no dependency
    drive(1, 2, 0, 0, 0, 0, 20, 1, 21, 22, "R8 no match");
    // R10: consecutive cycles toggle stall on and off
    drive(1, 2, 0, 0, 0, 0, 23, 1, 23, 0, "R10 on");
    drive(1, 2, 0, 0, 0, 0, 23, 0, 23, 0, "R10 off");

    // Sweep: varied patterns across all requirements
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] v1, v2, v3, v4, v5, v6, v7;
      v1 = AW'(i % 4);
      v2 = AW'((i / 4) % 4);
      v3 = AW'((i * 3) % 4);
      v4 = AW'((i * 7 + 1) % 4);
      v5 = AW'((i * 5) % 4);
      v6 = AW'((i / 2) % 4);
      v7 = AW'((i / 3) % 4);
      drive(v1, v2, v3, i[0], v4, i[1], v5, i[2], v6, v7, "R4 sweep");
    end

    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule